// File: doc/BRIEF.md
# Register Rename Status Table

This block holds the floating-point register values together with a small status field per register. The field names the reservation station that will produce the register's next value. A zero field means that no producer is outstanding. When an instruction issues, two source registers are looked up. Each lookup returns either a ready value or the tag of the station that the consumer must wait for, so the register name drops out of the instruction. In the same cycle the instruction's own station tag is written into the status of its destination register.

Finished results arrive on a tagged broadcast bus. A register accepts a broadcast only if its status still names that exact tag. If a later instruction has claimed the register since, the older result is dropped. This renaming removes write-after-read and write-after-write hazards. The station tags are 1 to 15, and tag 0 is reserved to mean "no producer".

Top module: `rename_status_table`

## Requirements
- R1: Asynchronous reset (rst_n low) clears every status field to 0 and every stored value to 0.
- R2: A lookup of a register whose status is 0 returns the stored value on the value output and 0 on the tag output.
- R3: A lookup of a register whose status is nonzero, with no matching broadcast that cycle, returns that status on the tag output and 0 on the value output.
- R4: When iss_valid and iss_wr are both 1, iss_tag is written into the status of register iss_dst at the clock edge, replacing any older pending tag. Lookups in that same cycle see the state from before the edge.
- R5: A broadcast (bc_valid 1, bc_tag nonzero) stores bc_data into each register whose status equals bc_tag, and clears that status to 0 at the same edge.
- R6: A broadcast whose tag differs from a register's status leaves that register's value and status unchanged, so a result from a superseded producer is discarded.
- R7: If a rename targets a register in the same cycle as a broadcast that matches that register's status, the register takes the new tag and keeps its old value.
- R8: A lookup of a register whose status equals the tag being broadcast in that cycle returns bc_data with tag 0.
- R9: A broadcast with bc_tag 0 changes no register, and an issue with iss_wr 0 changes no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_wr | input | 1 | The issuing instruction writes a destination register |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Station tag of the issuing instruction (nonzero) |
| rd_a_idx | input | 4 | First source register index |
| rd_b_idx | input | 4 | Second source register index |
| rd_a_val | output | 64 | First source value, or 0 when pending |
| rd_a_tag | output | 4 | First source producer tag, 0 when ready |
| rd_b_val | output | 64 | Second source value, or 0 when pending |
| rd_b_tag | output | 4 | Second source producer tag, 0 when ready |
| bc_valid | input | 1 | A result is on the broadcast bus |
| bc_tag | input | 4 | Station tag of the broadcast result |
| bc_data | input | 64 | Broadcast result value |

## Verification
The bench renames one register twice and then broadcasts the older tag. A design that compares only the destination index, or writes on any valid broadcast, would overwrite a newer producer's slot. It also renames a register in the same cycle that the register's current producer broadcasts. Letting the broadcast win there would leave the register marked ready while a newer producer is still in flight. Lookups are taken in the broadcast cycle to catch a missing bypass, which would hand a consumer a tag that is never broadcast again. A zero-tag broadcast is sent to catch a design that treats "blank" as a matching tag. Random traffic then mixes all of these cases and is compared on every cycle.

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NREG = 16,
  parameter int DW   = 64,
  parameter int TW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iss_valid,
  input  logic                    iss_wr,
  input  logic [$clog2(NREG)-1:0] iss_dst,
  input  logic [TW-1:0]           iss_tag,
  input  logic [$clog2(NREG)-1:0] rd_a_idx,
  input  logic [$clog2(NREG)-1:0] rd_b_idx,
  output logic [DW-1:0]           rd_a_val,
  output logic [TW-1:0]           rd_a_tag,
  output logic [DW-1:0]           rd_b_val,
  output logic [TW-1:0]           rd_b_tag,
  input  logic                    bc_valid,
  input  logic [TW-1:0]           bc_tag,
  input  logic [DW-1:0]           bc_data
);
  localparam int AW = $clog2(NREG);

  logic [TW-1:0] tag_q [NREG];
  logic [DW-1:0] val_q [NREG];
  logic [NREG-1:0] hit_v, claim_v;

  wire ren     = iss_valid && iss_wr;
  wire bc_live = bc_valid && (bc_tag != '0);

  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      hit_v[k]   = bc_live && (tag_q[k] == bc_tag);
      claim_v[k] = ren && (iss_dst == AW'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) begin
        tag_q[k] <= '0;
        val_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NREG; k++) begin
        if (claim_v[k]) begin
          tag_q[k] <= iss_tag;
        end else if (hit_v[k]) begin
          tag_q[k] <= '0;
          val_q[k] <= bc_data;
        end
      end
    end
  end

  wire [TW-1:0] ta   = tag_q[rd_a_idx];
  wire [TW-1:0] tb   = tag_q[rd_b_idx];
  wire          a_bp = bc_live && (ta == bc_tag);
  wire          b_bp = bc_live && (tb == bc_tag);

  assign rd_a_tag = (ta != '0 && !a_bp) ? ta : '0;
  assign rd_b_tag = (tb != '0 && !b_bp) ? tb : '0;
  assign rd_a_val = (ta == '0) ? val_q[rd_a_idx] : (a_bp ? bc_data : '0);
  assign rd_b_val = (tb == '0) ? val_q[rd_b_idx] : (b_bp ? bc_data : '0);

  // R3
  pend_val_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_tag != '0) |-> (rd_a_val == '0 && !(bc_live && rd_a_tag == bc_tag)));

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    // R4
    rename_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claim_v[k] |=> (tag_q[k] == $past(iss_tag)));
    // R5
    bc_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_v[k] && !claim_v[k]) |=> (tag_q[k] == '0 && val_q[k] == $past(bc_data)));
    // R6
    stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_v[k] && !claim_v[k]) |=> (tag_q[k] == $past(tag_q[k]) && val_q[k] == $past(val_q[k])));
    // R7
    claim_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claim_v[k] |=> (val_q[k] == $past(val_q[k])));
  end
endmodule

// File: tb/rename_status_table_tb_top.sv
module rename_status_table_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 0, iss_wr = 0, bc_valid = 0;
  logic [3:0] iss_dst = 0, iss_tag = 1, rd_a_idx = 0, rd_b_idx = 0, bc_tag = 0;
  logic [63:0] bc_data = 0;
  logic [63:0] rd_a_val, rd_b_val;
  logic [3:0] rd_a_tag, rd_b_tag;

  always #4 clk = ~clk;

  rename_status_table dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_wr(iss_wr),
    .iss_dst(iss_dst), .iss_tag(iss_tag), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_val(rd_a_val), .rd_a_tag(rd_a_tag), .rd_b_val(rd_b_val), .rd_b_tag(rd_b_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data));

  int compared = 0, mismatched = 0;
  logic [3:0]  m_tag [16];
  logic [63:0] m_val [16];

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model_rd(input logic [3:0] idx, output logic [3:0] t, output logic [63:0] v);
    if (m_tag[idx] == 0) begin t = 0; v = m_val[idx]; end
    else if (bc_valid && bc_tag != 0 && bc_tag == m_tag[idx]) begin t = 0; v = bc_data; end
    else begin t = m_tag[idx]; v = 0; end
  endtask

  task automatic cyc(input logic iv, input logic iw, input logic [3:0] dst, input logic [3:0] it,
                     input logic [3:0] ra, input logic [3:0] rb,
                     input logic bv, input logic [3:0] bt, input logic [63:0] bd, input string req);
    logic [3:0] et; logic [63:0] ev;
    logic [3:0] nt [16]; logic [63:0] nv [16];
    iss_valid = iv; iss_wr = iw; iss_dst = dst; iss_tag = it;
    rd_a_idx = ra; rd_b_idx = rb; bc_valid = bv; bc_tag = bt; bc_data = bd;
    #1;
    model_rd(ra, et, ev);
    chk({60'd0, rd_a_tag}, {60'd0, et}, {req, " rd_a_tag"});
    chk(rd_a_val, ev, {req, " rd_a_val"});
    model_rd(rb, et, ev);
    chk({60'd0, rd_b_tag}, {60'd0, et}, {req, " rd_b_tag"});
    chk(rd_b_val, ev, {req, " rd_b_val"});
    for (int i = 0; i < 16; i++) begin nt[i] = m_tag[i]; nv[i] = m_val[i]; end
    for (int i = 0; i < 16; i++) begin
      if (iv && iw && dst == i[3:0]) nt[i] = it;
      else if (bv && bt != 0 && m_tag[i] == bt) begin nt[i] = 0; nv[i] = bd; end
    end
    @(posedge clk);
    for (int i = 0; i < 16; i++) begin m_tag[i] = nt[i]; m_val[i] = nv[i]; end
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] ra, input logic [3:0] rb, input string req);
    cyc(0, 0, 0, 1, ra, rb, 0, 0, 64'd0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_tag[i] = 0; m_val[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) rd(i[3:0], 4'(15 - i), "R1");
    for (int i = 0; i < 16; i++) begin
      logic [3:0] t;
      t = 4'((i % 15) + 1);
      cyc(1, 1, i[3:0], t, i[3:0], i[3:0], 0, 0, 64'd0, "R4");
      rd(i[3:0], 4'(15 - i), "R3");
      cyc(0, 0, 0, 1, i[3:0], 0, 1, t, 64'hA000_0000_0000_0000 + 64'(i), "R8");
      rd(i[3:0], i[3:0], "R2");
    end
    cyc(1, 1, 3, 5, 3, 0, 0, 0, 64'd0, "R4");
    cyc(1, 1, 3, 7, 3, 3, 0, 0, 64'd0, "R4");
    cyc(0, 0, 0, 1, 3, 2, 1, 5, 64'hDEAD_0005, "R6");
    rd(3, 3, "R6");
    cyc(0, 0, 0, 1, 2, 3, 1, 7, 64'hBEEF_0007, "R5");
    rd(3, 2, "R5");
    cyc(1, 1, 4, 9, 4, 4, 0, 0, 64'd0, "R4");
    cyc(1, 1, 4, 10, 4, 5, 1, 9, 64'h1234_0009, "R7");
    rd(4, 4, "R7");
    cyc(0, 0, 0, 1, 4, 1, 1, 10, 64'h1234_000A, "R5");
    rd(4, 4, "R2");
    cyc(0, 0, 0, 1, 6, 7, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
    rd(6, 7, "R9");
    cyc(1, 0, 2, 3, 2, 2, 0, 0, 64'd0, "R9");
    rd(2, 2, "R9");
    for (int n = 0; n < 3000; n++) begin
      cyc(1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom_range(1, 15)),
          4'($urandom), 4'($urandom), 1'($urandom), 4'($urandom_range(0, 15)),
          {$urandom, $urandom}, "rand R5/R6/R7/R8");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule